// File: doc/BRIEF.md
# Integer Execute Unit with Load-High

This block is the integer execution stage of a 32-bit load/store RISC pipeline. Each cycle it takes an operation code, two 32-bit register values and a 16-bit immediate field. It computes one of these results: a sum, a difference, an immediate sum, a left shift by an immediate amount, a signed less-than flag, or a constant placed in the upper half of a word. Where an instruction calls for an immediate second operand, the 16-bit field is sign-extended to 32 bits first.

The arithmetic is combinational. A control decoder turns the operation code into a small set of strobes, and a datapath acts on those strobes. The top module registers the chosen value once, so the result appears on `result` one clock cycle after the inputs are sampled. Add and subtract wrap modulo 2^32 and give no overflow indication. The signed comparison uses the same adder, running it in subtract mode.

Top module: `aluExecTop`

## Requirements
- R1: While `rstN` is low, `result` is 0.
- R2: Every result appears on `result` one rising edge after the inputs are sampled. Operation codes: 0 add, 1 subtract, 2 add-immediate, 3 shift-left-immediate, 4 set-less-than, 5 set-less-than-immediate, 6 load-high, 7 reserved.
- R3: Code 0 gives `srcA + srcB` modulo 2^32. The sum 0x7FFFFFFF + 1 gives 0x80000000, with no error.
- R4: Code 1 gives `srcA - srcB` modulo 2^32. The difference 0 - 1 gives 0xFFFFFFFF.
- R5: Code 2 gives `srcA` plus `imm16` sign-extended from bit 15, modulo 2^32.
- R6: Code 3 gives `srcA` shifted left by `imm16[4:0]`, with zeros filled in from the right. Bits 15:5 of `imm16` have no effect.
- R7: Code 4 gives exactly 1 when `srcA` < `srcB` as signed two's-complement numbers, and 0 otherwise. Bits 31:1 are always 0.
- R8: Code 5 gives the same 0-or-1 result as code 4, but compares against the sign-extended `imm16`.
- R9: Code 6 gives `{imm16, 16'h0000}`. `srcA` and `srcB` have no effect.
- R10: Code 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | Operation select (encoding in R2) |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field from the instruction |
| result | output | 32 | Registered result |

## Verification
The checker tests several properties on every cycle: the zero result during reset, the wrap-around of the register add, the clear upper bits of both compare results, the zero fill in the low bits of a shift, the exact form of a load-high result, and the zero result of the reserved code. Other properties can only be shown by the scoreboard's directed and random scenarios. These are the sign handling of the compare near the most-negative value, the sign extension of the immediate for add-immediate and compare-immediate, and the fact that the upper shift-amount bits and the register inputs to load-high are ignored.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDI = 3'd2,
    OP_SLLI = 3'd3,
    OP_SLT  = 3'd4,
    OP_SLTI = 3'd5,
    OP_LHI  = 3'd6,
    OP_RSVD = 3'd7
  } aluOp_e;

  typedef enum logic [2:0] {
    SEL_SUM   = 3'd0,
    SEL_SHIFT = 3'd1,
    SEL_LESS  = 3'd2,
    SEL_HIGH  = 3'd3,
    SEL_ZERO  = 3'd4
  } resSel_e;

  typedef struct packed {
    logic    useImm;
    logic    negateB;
    resSel_e resSel;
  } aluCtrl_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [2:0] opCode,
  output aluCtrl_t   ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctrl.useImm  = 1'b0;
    ctrl.negateB = 1'b0;
    ctrl.resSel  = SEL_ZERO;
    case (op)
      OP_ADD:  ctrl.resSel = SEL_SUM;
      OP_SUB: begin
        ctrl.negateB = 1'b1;
        ctrl.resSel  = SEL_SUM;
      end
      OP_ADDI: begin
        ctrl.useImm = 1'b1;
        ctrl.resSel = SEL_SUM;
      end
      OP_SLLI: ctrl.resSel = SEL_SHIFT;
      OP_SLT: begin
        ctrl.negateB = 1'b1;
        ctrl.resSel  = SEL_LESS;
      end
      OP_SLTI: begin
        ctrl.useImm  = 1'b1;
        ctrl.negateB = 1'b1;
        ctrl.resSel  = SEL_LESS;
      end
      OP_LHI:  ctrl.resSel = SEL_HIGH;
      default: ctrl.resSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] resNext
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int PAD_W   = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] opBAdj;
  logic [DATA_W-1:0] sum;
  logic              overflow;
  logic              less;
  logic [DATA_W-1:0] highVal;
  logic [SHAMT_W-1:0] shamt;

  assign immExt = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign opB    = ctrl.useImm ? immExt : srcB;
  assign opBAdj = ctrl.negateB ? ~opB : opB;
  assign sum    = srcA + opBAdj + {{(DATA_W-1){1'b0}}, ctrl.negateB};

  // signed less-than taken from the subtraction: sign of difference, corrected on overflow
  assign overflow = (srcA[DATA_W-1] != opB[DATA_W-1]) && (sum[DATA_W-1] != srcA[DATA_W-1]);
  assign less     = sum[DATA_W-1] ^ overflow;

  assign highVal = {imm, {PAD_W{1'b0}}};

  // logarithmic left shifter, one stage per shift-amount bit
  assign shamt = imm[SHAMT_W-1:0];
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  assign stage[0] = srcA;
  for (genvar s = 0; s < SHAMT_W; s++) begin : gShift
    localparam int DIST = 1 << s;
    assign stage[s+1] = shamt[s] ? (stage[s] << DIST) : stage[s];
  end

  always_comb begin
    case (ctrl.resSel)
      SEL_SUM:   resNext = sum;
      SEL_SHIFT: resNext = stage[SHAMT_W];
      SEL_LESS:  resNext = {{(DATA_W-1){1'b0}}, less};
      SEL_HIGH:  resNext = highVal;
      default:   resNext = '0;
    endcase
  end

endmodule

// File: rtl/aluExecTop.sv
module aluExecTop
  import aluPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm16,
  output logic [DATA_W-1:0] result
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] resNext;

  aluControl uCtrl (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  aluDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) uPath (
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .imm    (imm16),
    .resNext(resNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= resNext;
  end

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opCode,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [IMM_W-1:0]  imm16,
  input logic [DATA_W-1:0] result
);

  localparam int PAD_W = DATA_W - IMM_W;

  // R1
  p_reset_zero_r1: assert property (@(posedge clk) !rstN |=> result == '0);

  // R3 with the one-cycle timing of R2
  p_add_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd0) |-> result == DATA_W'($past(srcA) + $past(srcB)));

  // R6
  p_shift_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd3) |->
      (result & ~({DATA_W{1'b1}} << $past(imm16[4:0]))) == '0);

  // R7 and R8
  p_less_bool_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(opCode) == 3'd4 || $past(opCode) == 3'd5)) |->
      result[DATA_W-1:1] == '0);

  // R9
  p_high_form_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd6) |-> result == {$past(imm16), {PAD_W{1'b0}}});

  // R10
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd7) |-> result == '0);

endmodule

bind aluExecTop aluChecker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) uChk (.*);

// File: tb/tb_aluExecTop.sv
module tb_aluExecTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] result;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       reqQ[$];

  always #2 clk = ~clk;

  aluExecTop dut (
    .clk(clk), .rstN(rstN), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .imm16(imm16), .result(result)
  );

  function automatic logic [31:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [15:0] im);
    logic [31:0] ie;
    ie = {{16{im[15]}}, im};
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a + ie;
      3'd3: return a << im[4:0];
      3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd5: return ($signed(a) < $signed(ie)) ? 32'd1 : 32'd0;
      3'd6: return {im, 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // driver: one item per cycle, applied on the falling edge
  task automatic drive(string req, logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [15:0] im);
    @(negedge clk);
    opCode = op; srcA = a; srcB = b; imm16 = im;
    expQ.push_back(model(op, a, b, im));
    reqQ.push_back(req);
  endtask

  // monitor: result is registered, compared shortly after the rising edge (R2)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        logic [31:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check({r, "/R2"}, result, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    // R1: result held at zero during reset with live inputs
    opCode = 3'd6; imm16 = 16'hABCD; srcA = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1", result, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 edge cases
    drive("R3", 3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0);
    drive("R3", 3'd0, 32'hFFFF_FFFF, 32'd1, 16'h0);
    drive("R3", 3'd0, 32'h8000_0000, 32'h8000_0000, 16'h0);
    // R4
    drive("R4", 3'd1, 32'd0, 32'd1, 16'h0);
    drive("R4", 3'd1, 32'h8000_0000, 32'd1, 16'h0);
    drive("R4", 3'd1, 32'd100, 32'd100, 16'h0);
    // R5 sign extension
    drive("R5", 3'd2, 32'd10, 32'hDEAD_BEEF, 16'hFFFF);
    drive("R5", 3'd2, 32'd0, 32'd0, 16'h8000);
    drive("R5", 3'd2, 32'd5, 32'd0, 16'h7FFF);
    // R6: upper immediate bits ignored
    drive("R6", 3'd3, 32'h0000_0001, 32'd0, 16'h001F);
    drive("R6", 3'd3, 32'hF0F0_F0F1, 32'd0, 16'hFFE3);
    drive("R6", 3'd3, 32'h1234_5678, 32'd0, 16'h0020);
    // R7 signed compare
    drive("R7", 3'd4, 32'h8000_0000, 32'd1, 16'h0);
    drive("R7", 3'd4, 32'd1, 32'h8000_0000, 16'h0);
    drive("R7", 3'd4, 32'hFFFF_FFFF, 32'd0, 16'h0);
    drive("R7", 3'd4, 32'd7, 32'd7, 16'h0);
    drive("R7", 3'd4, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
    // R8 compare against sign-extended immediate
    drive("R8", 3'd5, 32'hFFFF_FFFE, 32'd0, 16'hFFFF);
    drive("R8", 3'd5, 32'd0, 32'hFFFF_FFFF, 16'h8000);
    drive("R8", 3'd5, 32'd3, 32'd0, 16'h0004);
    // R9: register inputs have no effect
    drive("R9", 3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h002A);
    drive("R9", 3'd6, 32'h0, 32'h0, 16'hFFFF);
    // R10
    drive("R10", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);

    // random sweep of every code
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'(i % 8);
      case (op)
        3'd0: drive("R3", op, $urandom, $urandom, 16'($urandom));
        3'd1: drive("R4", op, $urandom, $urandom, 16'($urandom));
        3'd2: drive("R5", op, $urandom, $urandom, 16'($urandom));
        3'd3: drive("R6", op, $urandom, $urandom, 16'($urandom));
        3'd4: drive("R7", op, $urandom, $urandom, 16'($urandom));
        3'd5: drive("R8", op, $urandom, $urandom, 16'($urandom));
        3'd6: drive("R9", op, $urandom, $urandom, 16'($urandom));
        default: drive("R10", op, $urandom, $urandom, 16'($urandom));
      endcase
    end

    // R1: asynchronous reset clears a non-zero result
    drive("R9", 3'd6, 32'd0, 32'd0, 16'h5555);
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", result, 32'd0);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule